// File: doc/BRIEF.md
# Snooping MSI Coherence Subsystem

This block is a small shared-memory subsystem in which several private caches stay coherent by watching one shared broadcast bus. Each core owns a direct-mapped cache controller that keeps one of three line states: Modified, Shared or Invalid. A load that finds its line in Shared or Modified, or a store that finds its line in Modified, is served locally. Any other request waits for a bus grant and then broadcasts a read, a read-for-ownership, an upgrade or a writeback. All other controllers snoop that broadcast in the same cycle. They drop or downgrade their copies, and the Modified holder drives its data onto the bus. A flat memory model serves every request that no cache owns and absorbs all dirty data.

The bus is atomic: a transaction starts and ends in the single cycle in which it is granted. A round-robin arbiter decides which pending controller goes next. The bus command and address are brought out so that traffic can be observed. Cores use a valid/ready request port and get a one-cycle response pulse that carries the load data, or the store data echoed back.

Top module: `coh_snoop_system`

## Requirements
- R1: A store that does not hit a Modified line completes only after its bus transaction has moved every other cached copy of that line to Invalid. A later load from another core to that address therefore misses and returns the stored value.
- R2: No two caches ever hold the same address with one of them in Modified, and at most one cache acts as data owner in any bus transaction.
- R3: When no cache holds the requested line in Modified, memory supplies the data. Memory resets to all zeros.
- R4: A Modified line that is snooped by a read drops to Shared, supplies its data, and writes that data to memory. A cache that never held the line later reads the value from memory.
- R5: A Modified line that leaves a cache is written to memory, either on a snooped read-for-ownership or on eviction. On eviction a writeback transaction (command 4) runs before the refill, and the miss response arrives 3 cycles after acceptance.
- R6: A store to a line held in Shared issues an upgrade (command 3) and no read or read-for-ownership.
- R7: A load hit in Shared or Modified, or a store hit in Modified, responds exactly 1 cycle after acceptance with no bus transaction. A request is accepted on a clock edge where valid and ready are both high.
- R8: A miss whose bus request is granted at once responds 2 cycles after acceptance. A load miss issues a read (command 1) and a store miss issues a read-for-ownership (command 2). An idle bus shows command 0.
- R9: Grants go round-robin. After reset core 0 has first priority. After core i is granted, priority starts at core i+1 and wraps around.
- R10: When two cores holding the same Shared line store to it in the same cycle, the first one granted upgrades. The second one finds its copy invalidated and issues a read-for-ownership instead. The second store's value is the one that survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req_valid | input | NC | Per-core request valid |
| core_req_we | input | NC | Per-core request is a store |
| core_req_addr | input | NC*AW | Per-core address, core i in bits [i*AW +: AW] |
| core_req_wdata | input | NC*DW | Per-core store data |
| core_req_ready | output | NC | Per-core controller can accept a request |
| core_resp_valid | output | NC | Per-core one-cycle completion pulse |
| core_resp_rdata | output | NC*DW | Per-core load data, or the store data echoed back |
| bus_cmd_o | output | 3 | Current bus command: 0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback |
| bus_addr_o | output | AW | Current bus address |

## Verification
The bench targets the points where a loose protocol leaks stale data. A Modified line is read by another core and then evicted silently from every Shared holder; if the flush skipped memory, a third core would read zero. Eviction of a dirty line must show a writeback and a three-cycle latency, or the old data is lost. Two cores store to the same Shared line in one cycle; a design that lets the loser upgrade a copy that is already dead would end with two writers and the wrong final value. Arbitration rounds check that priority rotates instead of favouring low indices.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDX  = 3'd2,
        CMD_UPGR = 3'd3,
        CMD_WB   = 3'd4
    } bus_cmd_e;

    // State a snooping cache moves to when another cache broadcasts cmd.
    function automatic line_st_e snoop_next(line_st_e cur, bus_cmd_e cmd);
        case (cmd)
            CMD_RD:            return (cur == ST_M) ? ST_S : cur;
            CMD_RDX, CMD_UPGR: return ST_I;
            default:           return cur;
        endcase
    endfunction

    function automatic logic cmd_wants_data(bus_cmd_e cmd);
        return (cmd == CMD_RD) || (cmd == CMD_RDX);
    endfunction

endpackage

// File: rtl/coh_rr_arb.sv
module coh_rr_arb #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    logic [PW-1:0] last_q;

    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_q) + k) % N;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= PW'(N - 1);
        end else begin
            for (int i = 0; i < N; i++) begin
                if (gnt[i]) last_q <= PW'(i);
            end
        end
    end

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt)); // R9
    AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0); // R9

endmodule

// File: rtl/coh_mem.sv
module coh_mem #(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int NWORDS = 2 ** AW;

    logic [DW-1:0] words [NWORDS];

    assign rd_data = words[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NWORDS; i++) words[i] <= '0;
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/coh_l1_ctrl.sv
module coh_l1_ctrl
    import coh_pkg::*;
#(
    parameter int NSETS = 4,
    parameter int AW    = 5,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_we,
    input  logic [AW-1:0]              req_addr,
    input  logic [DW-1:0]              req_wdata,
    output logic                       req_ready,
    output logic                       resp_valid,
    output logic [DW-1:0]              resp_rdata,
    output logic                       bus_req,
    input  logic                       bus_gnt,
    output bus_cmd_e                   my_cmd,
    output logic [AW-1:0]              my_addr,
    output logic [DW-1:0]              my_data,
    input  bus_cmd_e                   bus_cmd,
    input  logic [AW-1:0]              bus_addr,
    input  logic [DW-1:0]              bus_fill,
    output logic                       snp_owner,
    output logic [DW-1:0]              snp_data,
    output line_st_e [NSETS-1:0]       st_o,
    output logic [NSETS-1:0][AW-$clog2(NSETS)-1:0] tag_o
);
    localparam int IW = $clog2(NSETS);
    localparam int TW = AW - IW;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } core_req_t;

    line_st_e [NSETS-1:0]          lst;
    logic [NSETS-1:0][TW-1:0]      ltag;
    logic [NSETS-1:0][DW-1:0]      ldata;
    logic                          pending;
    core_req_t                     pend;

    logic [IW-1:0] ridx, pidx, sidx;
    logic [TW-1:0] rtag, ptag, stag;
    logic          hit_ok, need_wb, own_s, bus_busy, snp_hit;

    assign ridx = req_addr[IW-1:0];
    assign rtag = req_addr[AW-1:IW];
    assign pidx = pend.addr[IW-1:0];
    assign ptag = pend.addr[AW-1:IW];
    assign sidx = bus_addr[IW-1:0];
    assign stag = bus_addr[AW-1:IW];

    assign hit_ok = (lst[ridx] != ST_I) && (ltag[ridx] == rtag)
                    && (!req_we || lst[ridx] == ST_M);

    // Another controller's transaction is on the bus this cycle.
    assign bus_busy  = (bus_cmd != CMD_NONE) && !bus_gnt;
    assign req_ready = !pending && !bus_busy;
    assign bus_req   = pending;

    // Decided at grant time so a copy lost while waiting is seen.
    assign need_wb = (lst[pidx] == ST_M) && (ltag[pidx] != ptag);
    assign own_s   = (lst[pidx] == ST_S) && (ltag[pidx] == ptag);

    always_comb begin
        if (need_wb)      my_cmd = CMD_WB;
        else if (!pend.we) my_cmd = CMD_RD;
        else if (own_s)   my_cmd = CMD_UPGR;
        else              my_cmd = CMD_RDX;
    end

    assign my_addr = need_wb ? {ltag[pidx], pidx} : pend.addr;
    assign my_data = ldata[pidx];

    assign snp_hit   = bus_busy && (bus_cmd != CMD_WB)
                       && (lst[sidx] != ST_I) && (ltag[sidx] == stag);
    assign snp_owner = snp_hit && (lst[sidx] == ST_M) && cmd_wants_data(bus_cmd);
    assign snp_data  = ldata[sidx];

    assign st_o  = lst;
    assign tag_o = ltag;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSETS; i++) lst[i] <= ST_I;
            ltag       <= '0;
            ldata      <= '0;
            pending    <= 1'b0;
            pend       <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_valid <= 1'b0;
            if (snp_hit) lst[sidx] <= snoop_next(lst[sidx], bus_cmd);

            if (req_valid && req_ready) begin
                if (hit_ok) begin
                    resp_valid <= 1'b1;
                    if (req_we) begin
                        ldata[ridx] <= req_wdata;
                        resp_rdata  <= req_wdata;
                    end else begin
                        resp_rdata  <= ldata[ridx];
                    end
                end else begin
                    pending <= 1'b1;
                    pend    <= '{we: req_we, addr: req_addr, wdata: req_wdata};
                end
            end

            if (pending && bus_gnt) begin
                if (need_wb) begin
                    lst[pidx] <= ST_I;
                end else begin
                    ltag[pidx]  <= ptag;
                    lst[pidx]   <= pend.we ? ST_M : ST_S;
                    ldata[pidx] <= pend.we ? pend.wdata : bus_fill;
                    resp_rdata  <= pend.we ? pend.wdata : bus_fill;
                    resp_valid  <= 1'b1;
                    pending     <= 1'b0;
                end
            end
        end
    end

    AST_SNOOP_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
        (snp_hit && (bus_cmd == CMD_RDX || bus_cmd == CMD_UPGR))
        |=> lst[$past(sidx)] == ST_I); // R1
    AST_HIT_STAYS_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && hit_ok) |=> (!bus_req && resp_valid)); // R7

endmodule

// File: rtl/coh_snoop_system.sv
module coh_snoop_system
    import coh_pkg::*;
#(
    parameter int NC    = 3,
    parameter int NSETS = 4,
    parameter int AW    = 5,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NC-1:0]    core_req_valid,
    input  logic [NC-1:0]    core_req_we,
    input  logic [NC*AW-1:0] core_req_addr,
    input  logic [NC*DW-1:0] core_req_wdata,
    output logic [NC-1:0]    core_req_ready,
    output logic [NC-1:0]    core_resp_valid,
    output logic [NC*DW-1:0] core_resp_rdata,
    output logic [2:0]       bus_cmd_o,
    output logic [AW-1:0]    bus_addr_o
);
    localparam int IW = $clog2(NSETS);
    localparam int TW = AW - IW;

    logic [NC-1:0]            breq, bgnt, owner;
    bus_cmd_e                 cmd_arr   [NC];
    logic [AW-1:0]            addr_arr  [NC];
    logic [DW-1:0]            data_arr  [NC];
    logic [DW-1:0]            snpd_arr  [NC];
    line_st_e [NSETS-1:0]     st_all    [NC];
    logic [NSETS-1:0][TW-1:0] tag_all   [NC];

    bus_cmd_e      bus_cmd;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, own_data, mem_rd, fill;
    logic          owner_any;

    coh_rr_arb #(.N(NC)) u_arb (
        .clk(clk), .rst(rst), .req(breq), .gnt(bgnt)
    );

    for (genvar g = 0; g < NC; g++) begin : g_core
        coh_l1_ctrl #(.NSETS(NSETS), .AW(AW), .DW(DW)) u_l1 (
            .clk        (clk),
            .rst        (rst),
            .req_valid  (core_req_valid[g]),
            .req_we     (core_req_we[g]),
            .req_addr   (core_req_addr[g*AW +: AW]),
            .req_wdata  (core_req_wdata[g*DW +: DW]),
            .req_ready  (core_req_ready[g]),
            .resp_valid (core_resp_valid[g]),
            .resp_rdata (core_resp_rdata[g*DW +: DW]),
            .bus_req    (breq[g]),
            .bus_gnt    (bgnt[g]),
            .my_cmd     (cmd_arr[g]),
            .my_addr    (addr_arr[g]),
            .my_data    (data_arr[g]),
            .bus_cmd    (bus_cmd),
            .bus_addr   (bus_addr),
            .bus_fill   (fill),
            .snp_owner  (owner[g]),
            .snp_data   (snpd_arr[g]),
            .st_o       (st_all[g]),
            .tag_o      (tag_all[g])
        );
    end

    always_comb begin
        bus_cmd   = CMD_NONE;
        bus_addr  = '0;
        bus_wdata = '0;
        owner_any = 1'b0;
        own_data  = '0;
        for (int i = 0; i < NC; i++) begin
            if (bgnt[i]) begin
                bus_cmd   = cmd_arr[i];
                bus_addr  = addr_arr[i];
                bus_wdata = data_arr[i];
            end
            if (owner[i]) begin
                owner_any = 1'b1;
                own_data  = snpd_arr[i];
            end
        end
    end

    assign fill = owner_any ? own_data : mem_rd;

    coh_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_en   ((bus_cmd == CMD_WB) || owner_any),
        .wr_addr (bus_addr),
        .wr_data (owner_any ? own_data : bus_wdata),
        .rd_addr (bus_addr),
        .rd_data (mem_rd)
    );

    assign bus_cmd_o  = bus_cmd;
    assign bus_addr_o = bus_addr;

    // Cross-cache checks over the state every controller exports.
    logic swmr_bad, m_elsewhere;
    always_comb begin
        swmr_bad = 1'b0;
        for (int s = 0; s < NSETS; s++) begin
            for (int i = 0; i < NC; i++) begin
                for (int j = i + 1; j < NC; j++) begin
                    if (st_all[i][s] != ST_I && st_all[j][s] != ST_I
                        && tag_all[i][s] == tag_all[j][s]
                        && (st_all[i][s] == ST_M || st_all[j][s] == ST_M))
                        swmr_bad = 1'b1;
                end
            end
        end
        m_elsewhere = 1'b0;
        for (int i = 0; i < NC; i++) begin
            if (!bgnt[i] && st_all[i][bus_addr[IW-1:0]] == ST_M
                && tag_all[i][bus_addr[IW-1:0]] == bus_addr[AW-1:IW])
                m_elsewhere = 1'b1;
        end
    end

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !swmr_bad); // R2
    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot0(owner)); // R2
    AST_MEM_SOURCE_OK: assert property (@(posedge clk) disable iff (rst)
        (cmd_wants_data(bus_cmd) && !owner_any) |-> !m_elsewhere); // R3

endmodule

// File: tb/coh_snoop_system_test.sv
module coh_snoop_system_test;
    localparam int NC = 3;
    localparam int AW = 5;
    localparam int DW = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NC-1:0]    core_req_valid = '0;
    logic [NC-1:0]    core_req_we = '0;
    logic [NC*AW-1:0] core_req_addr = '0;
    logic [NC*DW-1:0] core_req_wdata = '0;
    logic [NC-1:0]    core_req_ready;
    logic [NC-1:0]    core_resp_valid;
    logic [NC*DW-1:0] core_resp_rdata;
    logic [2:0]       bus_cmd_o;
    logic [AW-1:0]    bus_addr_o;

    int checks = 0;
    int errors = 0;
    int tot_rd = 0, tot_rdx = 0, tot_upgr = 0, tot_wb = 0;
    int b_rd, b_rdx, b_upgr, b_wb;

    coh_snoop_system #(.NC(NC), .NSETS(4), .AW(AW), .DW(DW)) uut (.*);

    always #2 clk = ~clk;

    always @(negedge clk) begin
        if (!rst) begin
            case (bus_cmd_o)
                3'd1: tot_rd++;
                3'd2: tot_rdx++;
                3'd3: tot_upgr++;
                3'd4: tot_wb++;
                default: ;
            endcase
        end
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        chk(act == exp, req, what, act, exp);
    endtask

    task automatic snap();
        b_rd = tot_rd; b_rdx = tot_rdx; b_upgr = tot_upgr; b_wb = tot_wb;
    endtask

    task automatic do_op(input int c, input bit we, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, output logic [DW-1:0] rd,
                         output int lat);
        bit done;
        @(negedge clk);
        while (!core_req_ready[c]) @(negedge clk);
        snap();
        core_req_valid[c]         = 1'b1;
        core_req_we[c]            = we;
        core_req_addr[c*AW +: AW] = a;
        core_req_wdata[c*DW +: DW] = d;
        @(posedge clk);
        #1 core_req_valid[c] = 1'b0;
        lat = 0; rd = '0; done = 1'b0;
        for (int k = 0; k < 20 && !done; k++) begin
            @(negedge clk);
            lat++;
            if (core_resp_valid[c]) begin
                rd   = core_resp_rdata[c*DW +: DW];
                done = 1'b1;
            end
        end
    endtask

    task automatic do_pair(input int c0, input bit we0, input logic [AW-1:0] a0,
                           input logic [DW-1:0] d0,
                           input int c1, input bit we1, input logic [AW-1:0] a1,
                           input logic [DW-1:0] d1,
                           output logic [DW-1:0] rd0, output int lat0,
                           output logic [DW-1:0] rd1, output int lat1);
        @(negedge clk);
        snap();
        core_req_valid[c0] = 1'b1; core_req_we[c0] = we0;
        core_req_addr[c0*AW +: AW] = a0; core_req_wdata[c0*DW +: DW] = d0;
        core_req_valid[c1] = 1'b1; core_req_we[c1] = we1;
        core_req_addr[c1*AW +: AW] = a1; core_req_wdata[c1*DW +: DW] = d1;
        @(posedge clk);
        #1;
        core_req_valid[c0] = 1'b0;
        core_req_valid[c1] = 1'b0;
        lat0 = 0; lat1 = 0; rd0 = '0; rd1 = '0;
        for (int k = 1; k <= 20 && (lat0 == 0 || lat1 == 0); k++) begin
            @(negedge clk);
            if (core_resp_valid[c0]) begin lat0 = k; rd0 = core_resp_rdata[c0*DW +: DW]; end
            if (core_resp_valid[c1]) begin lat1 = k; rd1 = core_resp_rdata[c1*DW +: DW]; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_eq("reset", "ready all", int'(core_req_ready), 7);
        chk_eq("reset", "resp_valid", int'(core_resp_valid), 0);
        chk_eq("R8", "idle bus cmd", int'(bus_cmd_o), 0);
    endtask

    task automatic t_round_robin();
        logic [DW-1:0] r0, r1; int l0, l1;
        do_pair(0, 1'b0, 5'h02, 8'h0, 1, 1'b0, 5'h03, 8'h0, r0, l0, r1, l1);
        chk_eq("R9", "core0 first after reset latency", l0, 2);
        chk_eq("R9", "core1 second latency", l1, 3);
        chk_eq("R3", "memory zero data", int'(r0), 0);
        chk_eq("R8", "reads issued", tot_rd - b_rd, 2);
        do_pair(1, 1'b0, 5'h06, 8'h0, 2, 1'b0, 5'h07, 8'h0, r1, l1, r0, l0);
        chk_eq("R9", "core2 wins rotated round", l0, 2);
        chk_eq("R9", "core1 waits rotated round", l1, 3);
    endtask

    task automatic t_hits();
        logic [DW-1:0] r; int l;
        do_op(0, 1'b1, 5'h01, 8'h11, r, l);
        chk_eq("R8", "store miss latency", l, 2);
        chk_eq("R8", "store miss rdx", tot_rdx - b_rdx, 1);
        do_op(0, 1'b1, 5'h01, 8'h12, r, l);
        chk_eq("R7", "store hit M latency", l, 1);
        chk_eq("R7", "store hit bus silent", (tot_rd+tot_rdx+tot_upgr+tot_wb)-(b_rd+b_rdx+b_upgr+b_wb), 0);
        do_op(0, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R7", "load hit M latency", l, 1);
        chk_eq("R7", "load hit data", int'(r), 'h12);
    endtask

    task automatic t_flush_on_read();
        logic [DW-1:0] r; int l;
        do_op(1, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R4", "owner supplies dirty data", int'(r), 'h12);
        chk_eq("R8", "load miss latency", l, 2);
        chk_eq("R8", "load miss uses read", tot_rd - b_rd, 1);
        do_op(0, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R4", "former owner now S hit latency", l, 1);
        do_op(0, 1'b0, 5'h05, 8'h0, r, l);
        chk_eq("R5", "S eviction no writeback", tot_wb - b_wb, 0);
        chk_eq("R3", "conflict load from memory", int'(r), 0);
        do_op(1, 1'b0, 5'h05, 8'h0, r, l);
        chk_eq("R8", "second eviction latency", l, 2);
        do_op(2, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R4", "memory updated at M to S", int'(r), 'h12);
    endtask

    task automatic t_upgrade();
        logic [DW-1:0] r; int l;
        do_op(2, 1'b1, 5'h01, 8'h33, r, l);
        chk_eq("R6", "upgrade issued", tot_upgr - b_upgr, 1);
        chk_eq("R6", "no data fetch on upgrade", (tot_rd - b_rd) + (tot_rdx - b_rdx), 0);
        chk_eq("R6", "upgrade latency", l, 2);
        do_op(0, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R1", "reader sees upgraded store", int'(r), 'h33);
    endtask

    task automatic t_steal();
        logic [DW-1:0] r; int l;
        do_op(1, 1'b1, 5'h01, 8'h44, r, l);
        chk_eq("R8", "store miss rdx again", tot_rdx - b_rdx, 1);
        do_op(0, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R1", "old S copy invalidated (miss)", l, 2);
        chk_eq("R1", "new value after steal", int'(r), 'h44);
        do_op(2, 1'b0, 5'h01, 8'h0, r, l);
        chk_eq("R1", "second sharer invalidated", l, 2);
        chk_eq("R5", "value after RdX flush", int'(r), 'h44);
    endtask

    task automatic t_evict_dirty();
        logic [DW-1:0] r; int l;
        do_op(0, 1'b1, 5'h09, 8'h55, r, l);
        do_op(0, 1'b0, 5'h0D, 8'h0, r, l);
        chk_eq("R5", "dirty eviction writeback", tot_wb - b_wb, 1);
        chk_eq("R5", "dirty eviction latency", l, 3);
        chk_eq("R3", "refill data", int'(r), 0);
        do_op(2, 1'b0, 5'h09, 8'h0, r, l);
        chk_eq("R5", "written-back value from memory", int'(r), 'h55);
    endtask

    task automatic t_race();
        logic [DW-1:0] r0, r1, r; int l0, l1, l;
        int last_val;
        do_op(0, 1'b0, 5'h10, 8'h0, r, l);
        do_op(1, 1'b0, 5'h10, 8'h0, r, l);
        do_pair(0, 1'b1, 5'h10, 8'hA0, 1, 1'b1, 5'h10, 8'hB1, r0, l0, r1, l1);
        chk_eq("R10", "one upgrade", tot_upgr - b_upgr, 1);
        chk_eq("R10", "loser uses rdx", tot_rdx - b_rdx, 1);
        chk(l0 != l1 && l0 > 0 && l1 > 0, "R10", "distinct completion", l0, l1 + 1);
        last_val = (l1 > l0) ? 'hB1 : 'hA0;
        do_op(2, 1'b0, 5'h10, 8'h0, r, l);
        chk_eq("R10", "later store survives", int'(r), last_val);
        do_op((l1 > l0) ? 0 : 1, 1'b0, 5'h10, 8'h0, r, l);
        chk_eq("R2", "earlier writer lost M (miss)", l, 2);
        chk_eq("R2", "earlier writer sees final", int'(r), last_val);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_round_robin();
        t_hits();
        t_flush_on_read();
        t_upgrade();
        t_steal();
        t_evict_dirty();
        t_race();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule